// File: doc/BRIEF.md
# Switch Bring-Up Sequencer

This block brings a seven-port Ethernet switch from an unknown state to a simple forwarding setup. It does this through an abstract register port that addresses 16-bit registers by a 5-bit device address and a 5-bit register offset. A single `start` pulse runs a fixed program. First, every port is placed in the disabled state. The sequencer then pauses so that the switch queues can empty, requests a soft reset, and polls until the reset reports completion. The poll has a limited number of attempts. After the reset completes, the sequencer names the CPU port as the management destination. It then gives the CPU port a membership map that reaches every other port, and gives each selected non-CPU port a map that reaches only the CPU port. Each configured port receives a default VLAN ID and is placed in the forwarding state.

Every field change is a read followed by a write of the merged word, so bits outside the field are kept. Two delays are given in microseconds and turned into cycle counts from a clock-frequency parameter: the queue-drain pause and the interval between reset polls. The CPU port number and the set of forwarding ports are captured when `start` is accepted. The outcome is reported as a `done` level or a `timed_out` level, and both stay valid until the next start.

Top module: `swinit_seq`

## Requirements
- R1: After reset, `busy`, `done`, `timed_out` and `bus_req` are all 0, and no request appears on the register port while the block is idle.
- R2: The first seven writes of a run target device 0x10+p, register 0x04, for p = 0,1,...,6 in increasing order. Each write carries the value read from that register with bits 1:0 cleared and all other bits kept.
- R3: The soft-reset write is not acknowledged until at least DRAIN_US×CLK_HZ/10^6 cycles after the last port-disable write is acknowledged.
- R4: The eighth write sets bit 15 of device 0x1B, register 0x04, and keeps the other bits. The block then reads that register until bit 15 reads 0. Successive poll reads are at least POLL_US×CLK_HZ/10^6 cycles apart.
- R5: If bit 15 still reads 1 on the POLL_MAX-th poll read, the run ends with `timed_out`=1 and `done`=0, and no write follows the soft-reset write.
- R6: After a successful reset, bits 7:4 of device 0x1B, register 0x1A, hold the CPU port number, and the other bits are kept.
- R7: For the CPU port and each enabled port, bits 11:0 of register 0x07 (device 0x10+p) become p+1 and bits 15:12 are kept. The VID register of any other port is not written.
- R8: Bits 10:0 of register 0x06 become the seven-port mask without the CPU bit for the CPU port, and only the CPU bit for each other enabled port. Bits 15:11 are kept.
- R9: Bits 1:0 of register 0x04 end at 3 (forwarding) for the CPU port and every port whose `fwd_ports` bit is set. They end at 0 for all other ports.
- R10: A `fwd_ports` bit at the CPU port's position has no effect: the CPU port is configured only once, with the CPU map, and a successful run makes exactly 12+3n writes, where n counts the set `fwd_ports` bits other than the CPU bit.
- R11: Every write on the register port goes to the device and register of the immediately preceding read.
- R12: While `busy` is 1, `done` and `timed_out` are 0, and a `start` pulse is ignored (the captured configuration is used). A successful run ends with `done`=1.
- R13: Once raised, `bus_req` and its command fields stay unchanged until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| cpu_port | input | 3 | Port number of the CPU port (0..6), captured at start |
| fwd_ports | input | 7 | Ports to put into forwarding, captured at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed successfully |
| timed_out | output | 1 | Last run failed in the reset poll |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_dev | output | 5 | Device address of the access |
| bus_reg | output | 5 | Register offset of the access |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access complete; read data valid in the same cycle |
| bus_rdata | input | 16 | Read data |

## Verification
A request is issued one clock after the sequencer enters a step. Its acknowledge arrives a fixed latency later, and the next request follows one clock after that acknowledge. Because of this, per-access timing is not measured. Instead, the bench's register model records every acknowledged access together with its cycle count. The drain gap (R3) and the poll gap (R4) are checked as differences between those recorded cycles, which bounds them from below no matter how many pipeline registers sit on the path. Final register contents and the outcome levels are read on the falling edge after `done` or `timed_out` rises, since both are registered at the same edge on which `busy` falls.

// File: rtl/swinit_pkg.sv
// Package: shared constants and types for the switch bring-up sequencer.
// Assumes a register space of 32 devices x 32 registers, 16 bits each.
package swinit_pkg;
    localparam int DW = 16;
    localparam int AW = 5;

    localparam logic [AW-1:0] DEV_PORT_BASE = 5'h10;
    localparam logic [AW-1:0] DEV_GLOBAL    = 5'h1B;

    localparam logic [AW-1:0] REG_PORT_CTRL = 5'h04;
    localparam logic [AW-1:0] REG_PORT_MAP  = 5'h06;
    localparam logic [AW-1:0] REG_PORT_VID  = 5'h07;
    localparam logic [AW-1:0] REG_GLB_CTRL  = 5'h04;
    localparam logic [AW-1:0] REG_GLB_MON   = 5'h1A;

    localparam logic [DW-1:0] FLD_PSTATE  = 16'h0003;
    localparam logic [DW-1:0] FLD_SWRST   = 16'h8000;
    localparam logic [DW-1:0] FLD_CPUDEST = 16'h00F0;
    localparam logic [DW-1:0] FLD_MAP     = 16'h07FF;
    localparam logic [DW-1:0] FLD_VID     = 16'h0FFF;

    localparam logic [DW-1:0] PSTATE_OFF = 16'h0000;
    localparam logic [DW-1:0] PSTATE_FWD = 16'h0003;

    localparam int SWRST_BIT   = 15;
    localparam int CPUDEST_LSB = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_DIS, S_DRAIN, S_RSTSET, S_POLL, S_PWAIT,
        S_CPUDEST, S_CVID, S_CMAP, S_CEN,
        S_SCAN, S_PEN, S_PVID, S_PMAP
    } seq_state_e;

    typedef enum logic [1:0] { R_IDLE, R_RD, R_WR } rmw_phase_e;

    typedef struct packed {
        logic [AW-1:0] dev;
        logic [AW-1:0] rg;
        logic [DW-1:0] mask;
        logic [DW-1:0] val;
        logic          rd_only;
    } rmw_cmd_t;
endpackage

// File: rtl/swinit_timer.sv
// Module: one-shot down-counter. A load pulse arms it with a length of
// at least 1; fin pulses once, no earlier than len cycles after the load.
module swinit_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          fin
);
    logic [CW-1:0] cnt;
    logic          run;

    // Count down the armed interval and pulse fin at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                cnt <= len - CW'(1);
                run <= 1'b1;
            end else if (run) begin
                if (cnt == '0) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/swinit_rmw.sv
// Module: read-modify-write engine on the register port. go latches a
// command; the engine reads the register and, unless rd_only is set, writes
// back (old & ~mask) | (val & mask). fin pulses when the last access is
// acknowledged. rd_flag holds bit FLAG_BIT of the word read.
// Assumes the port acknowledges every request eventually.
module swinit_rmw
    import swinit_pkg::*;
#(
    parameter int FLAG_BIT = SWRST_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  rmw_cmd_t      cmd,
    output logic          fin,
    output logic          rd_flag,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_dev,
    output logic [AW-1:0] bus_reg,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata
);
    rmw_phase_e    ph;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] val_q;
    logic          rd_only_q;

    // Walk read then optional write, holding each request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= R_IDLE;
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_dev   <= '0;
            bus_reg   <= '0;
            bus_wdata <= '0;
            mask_q    <= '0;
            val_q     <= '0;
            rd_only_q <= 1'b0;
            fin       <= 1'b0;
            rd_flag   <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (ph)
                R_IDLE: begin
                    if (go) begin
                        bus_dev   <= cmd.dev;
                        bus_reg   <= cmd.rg;
                        mask_q    <= cmd.mask;
                        val_q     <= cmd.val;
                        rd_only_q <= cmd.rd_only;
                        bus_we    <= 1'b0;
                        bus_req   <= 1'b1;
                        ph        <= R_RD;
                    end
                end
                R_RD: begin
                    if (bus_ack) begin
                        rd_flag <= bus_rdata[FLAG_BIT];
                        if (rd_only_q) begin
                            bus_req <= 1'b0;
                            fin     <= 1'b1;
                            ph      <= R_IDLE;
                        end else begin
                            bus_we    <= 1'b1;
                            bus_wdata <= (bus_rdata & ~mask_q) | (val_q & mask_q);
                            ph        <= R_WR;
                        end
                    end
                end
                R_WR: begin
                    if (bus_ack) begin
                        bus_req <= 1'b0;
                        bus_we  <= 1'b0;
                        fin     <= 1'b1;
                        ph      <= R_IDLE;
                    end
                end
                default: ph <= R_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swinit_seq.sv
// Module: top of the switch bring-up sequencer. It disables all ports, waits
// for the queues to drain, soft-resets the switch, polls for completion
// (bounded), then programs the CPU destination, VLAN maps and default VIDs,
// and enables forwarding. Assumes cpu_port < NPORTS, NPORTS <= 11, and that
// the register port acknowledges every access.
module swinit_seq
    import swinit_pkg::*;
#(
    parameter int NPORTS   = 7,
    parameter int CLK_HZ   = 125_000_000,
    parameter int DRAIN_US = 2000,
    parameter int POLL_US  = 1000,
    parameter int POLL_MAX = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [$clog2(NPORTS+1)-1:0] cpu_port,
    input  logic [NPORTS-1:0]      fwd_ports,
    output logic                   busy,
    output logic                   done,
    output logic                   timed_out,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [AW-1:0]          bus_dev,
    output logic [AW-1:0]          bus_reg,
    output logic [DW-1:0]          bus_wdata,
    input  logic                   bus_ack,
    input  logic [DW-1:0]          bus_rdata
);
    localparam int PW        = $clog2(NPORTS + 1);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int DRAIN_CYC = CYC_PER_US * DRAIN_US;
    localparam int POLL_CYC  = CYC_PER_US * POLL_US;
    localparam int TMAX      = (DRAIN_CYC > POLL_CYC) ? DRAIN_CYC : POLL_CYC;
    localparam int TCW       = $clog2(TMAX + 1);
    localparam int PCW       = $clog2(POLL_MAX + 1);

    seq_state_e        state;
    logic [PW-1:0]     pidx;
    logic [PW-1:0]     cpu_q;
    logic [NPORTS-1:0] fwd_q;
    logic [PCW-1:0]    tries;
    logic              launched;

    logic              is_rmw, is_wait, go, tmr_load;
    logic              rmw_fin, tmr_fin, rd_flag;
    logic [TCW-1:0]    tmr_len;
    rmw_cmd_t          cmd;
    logic [PW-1:0]     tgt;
    logic [NPORTS-1:0] cpu_onehot;
    logic [NPORTS-1:0] all_but_cpu;

    assign busy = (state != S_IDLE);

    // Classify the current step as a register access or a timed wait.
    always_comb begin
        is_rmw  = 1'b0;
        is_wait = 1'b0;
        case (state)
            S_DIS, S_RSTSET, S_POLL, S_CPUDEST, S_CVID, S_CMAP, S_CEN,
            S_PEN, S_PVID, S_PMAP: is_rmw = 1'b1;
            S_DRAIN, S_PWAIT:      is_wait = 1'b1;
            default: ;
        endcase
    end

    assign go       = is_rmw  && !launched;
    assign tmr_load = is_wait && !launched;
    assign tmr_len  = (state == S_DRAIN) ? TCW'(DRAIN_CYC) : TCW'(POLL_CYC);

    // Derive the VLAN membership masks from the captured CPU port.
    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            cpu_onehot[i]  = (cpu_q == PW'(i));
            all_but_cpu[i] = (cpu_q != PW'(i));
        end
    end

    // Build the field command for the current step.
    always_comb begin
        tgt         = (state == S_CVID || state == S_CMAP || state == S_CEN) ? cpu_q : pidx;
        cmd.dev     = DEV_PORT_BASE + AW'(tgt);
        cmd.rg      = REG_PORT_CTRL;
        cmd.mask    = FLD_PSTATE;
        cmd.val     = PSTATE_OFF;
        cmd.rd_only = 1'b0;
        case (state)
            S_CEN, S_PEN: cmd.val = PSTATE_FWD;
            S_RSTSET: begin
                cmd.dev  = DEV_GLOBAL;
                cmd.rg   = REG_GLB_CTRL;
                cmd.mask = FLD_SWRST;
                cmd.val  = FLD_SWRST;
            end
            S_POLL: begin
                cmd.dev     = DEV_GLOBAL;
                cmd.rg      = REG_GLB_CTRL;
                cmd.mask    = '0;
                cmd.rd_only = 1'b1;
            end
            S_CPUDEST: begin
                cmd.dev  = DEV_GLOBAL;
                cmd.rg   = REG_GLB_MON;
                cmd.mask = FLD_CPUDEST;
                cmd.val  = DW'(cpu_q) << CPUDEST_LSB;
            end
            S_CVID, S_PVID: begin
                cmd.rg   = REG_PORT_VID;
                cmd.mask = FLD_VID;
                cmd.val  = DW'(tgt) + DW'(1);
            end
            S_CMAP: begin
                cmd.rg   = REG_PORT_MAP;
                cmd.mask = FLD_MAP;
                cmd.val  = DW'(all_but_cpu);
            end
            S_PMAP: begin
                cmd.rg   = REG_PORT_MAP;
                cmd.mask = FLD_MAP;
                cmd.val  = DW'(cpu_onehot);
            end
            default: ;
        endcase
    end

    swinit_rmw #(.FLAG_BIT(SWRST_BIT)) rmw_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cmd       (cmd),
        .fin       (rmw_fin),
        .rd_flag   (rd_flag),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_dev   (bus_dev),
        .bus_reg   (bus_reg),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    swinit_timer #(.CW(TCW)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .fin   (tmr_fin)
    );

    // Step the bring-up program and record its outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            pidx      <= '0;
            cpu_q     <= '0;
            fwd_q     <= '0;
            tries     <= '0;
            launched  <= 1'b0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            if (go || tmr_load)          launched <= 1'b1;
            else if (rmw_fin || tmr_fin) launched <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        cpu_q     <= cpu_port;
                        fwd_q     <= fwd_ports;
                        done      <= 1'b0;
                        timed_out <= 1'b0;
                        pidx      <= '0;
                        state     <= S_DIS;
                    end
                end
                S_DIS: if (rmw_fin) begin
                    if (pidx == PW'(NPORTS - 1)) begin
                        pidx  <= '0;
                        state <= S_DRAIN;
                    end else begin
                        pidx <= pidx + PW'(1);
                    end
                end
                S_DRAIN: if (tmr_fin) state <= S_RSTSET;
                S_RSTSET: if (rmw_fin) begin
                    tries <= '0;
                    state <= S_POLL;
                end
                S_POLL: if (rmw_fin) begin
                    if (!rd_flag) begin
                        state <= S_CPUDEST;
                    end else if (tries == PCW'(POLL_MAX - 1)) begin
                        timed_out <= 1'b1;
                        state     <= S_IDLE;
                    end else begin
                        tries <= tries + PCW'(1);
                        state <= S_PWAIT;
                    end
                end
                S_PWAIT:   if (tmr_fin) state <= S_POLL;
                S_CPUDEST: if (rmw_fin) state <= S_CVID;
                S_CVID:    if (rmw_fin) state <= S_CMAP;
                S_CMAP:    if (rmw_fin) state <= S_CEN;
                S_CEN: if (rmw_fin) begin
                    pidx  <= '0;
                    state <= S_SCAN;
                end
                S_SCAN: begin
                    if (pidx == PW'(NPORTS)) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (fwd_q[pidx] && pidx != cpu_q) begin
                        state <= S_PEN;
                    end else begin
                        pidx <= pidx + PW'(1);
                    end
                end
                S_PEN:  if (rmw_fin) state <= S_PVID;
                S_PVID: if (rmw_fin) state <= S_PMAP;
                S_PMAP: if (rmw_fin) begin
                    pidx  <= pidx + PW'(1);
                    state <= S_SCAN;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/swinit_seq_chk.sv
// Module: protocol and outcome checker for swinit_seq, attached by bind.
// Tracks the address of the last acknowledged read to check write pairing.
module swinit_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        timed_out,
    input logic        bus_req,
    input logic        bus_we,
    input logic [4:0]  bus_dev,
    input logic [4:0]  bus_reg,
    input logic [15:0] bus_wdata,
    input logic        bus_ack
);
    logic [9:0] last_rd;
    logic       rd_seen;

    // Remember which register the most recent read targeted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd <= '0;
            rd_seen <= 1'b0;
        end else if (bus_req && bus_ack && !bus_we) begin
            last_rd <= {bus_dev, bus_reg};
            rd_seen <= 1'b1;
        end
    end

    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_dev)
                                   && $stable(bus_reg) && $stable(bus_wdata)));

    a_r11_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (rd_seen && {bus_dev, bus_reg} == last_rd));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    a_r12_busy_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !timed_out));

    a_r5_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timed_out));
endmodule

bind swinit_seq swinit_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .timed_out (timed_out),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_dev   (bus_dev),
    .bus_reg   (bus_reg),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/swinit_seq_tb.sv
// Bench: sweeps every CPU port against several forwarding masks and reset-poll
// lengths, with a register-file model behind the bus and arithmetic expectations.
module swinit_seq_tb_top;
    localparam int NP       = 7;
    localparam int CLK_HZ   = 1_000_000;
    localparam int DRAIN_US = 20;
    localparam int POLL_US  = 5;
    localparam int POLL_MAX = 6;
    localparam int DRAIN_C  = DRAIN_US;
    localparam int POLL_C   = POLL_US;
    localparam int LAT      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cpu_port = '0;
    logic [6:0]  fwd_ports = '0;
    logic        busy, done, timed_out;
    logic        bus_req, bus_we;
    logic [4:0]  bus_dev, bus_reg;
    logic [15:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    swinit_seq #(.NPORTS(NP), .CLK_HZ(CLK_HZ), .DRAIN_US(DRAIN_US),
                 .POLL_US(POLL_US), .POLL_MAX(POLL_MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cpu_port(cpu_port),
        .fwd_ports(fwd_ports), .busy(busy), .done(done), .timed_out(timed_out),
        .bus_req(bus_req), .bus_we(bus_we), .bus_dev(bus_dev), .bus_reg(bus_reg),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // Register-file model with access log
    logic [15:0] mem [32][32];
    logic [4:0]  wd  [64];
    logic [4:0]  wrg [64];
    logic [15:0] wdat[64];
    int          wcyc[64];
    int          prd_cyc[64];
    int wr_n = 0, prd_n = 0, cyc = 0, lat_cnt = 0, rst_left = 0, rst_cfg = 0;
    bit rst_armed = 0, do_init = 0;

    function automatic logic [15:0] seedv(int d, int r);
        return 16'(32'hA5C3 ^ (d * 32'h0111) ^ (r * 32'h1357));
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (do_init) begin
            for (int d = 0; d < 32; d++)
                for (int r = 0; r < 32; r++) mem[d][r] = seedv(d, r);
            wr_n <= 0; prd_n <= 0; rst_armed <= 0; bus_ack <= 0; lat_cnt <= 0;
        end else begin
            bus_ack <= 1'b0;
            if (bus_req && !bus_ack) begin
                if (lat_cnt == LAT) begin
                    lat_cnt <= 0;
                    bus_ack <= 1'b1;
                    if (bus_we) begin
                        mem[bus_dev][bus_reg] = bus_wdata;
                        if (wr_n < 64) begin
                            wd[wr_n] <= bus_dev; wrg[wr_n] <= bus_reg;
                            wdat[wr_n] <= bus_wdata; wcyc[wr_n] <= cyc;
                        end
                        wr_n <= wr_n + 1;
                        if (bus_dev == 5'h1B && bus_reg == 5'h04 && bus_wdata[15]) begin
                            rst_armed <= 1; rst_left <= rst_cfg;
                        end
                    end else if (bus_dev == 5'h1B && bus_reg == 5'h04 && rst_armed) begin
                        if (prd_n < 64) prd_cyc[prd_n] <= cyc;
                        prd_n <= prd_n + 1;
                        if (rst_left > 0) begin
                            bus_rdata <= mem[5'h1B][5'h04];
                            rst_left <= rst_left - 1;
                        end else begin
                            mem[5'h1B][5'h04] = mem[5'h1B][5'h04] & 16'h7FFF;
                            bus_rdata <= mem[5'h1B][5'h04];
                        end
                    end else begin
                        bus_rdata <= mem[bus_dev][bus_reg];
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic run(input int cpu, input logic [6:0] fwd, input int rreads, input bit mid);
        int n, waitc, pcount, en, d;
        bit exp_to;
        logic [15:0] s, e;
        @(negedge clk); do_init = 1; rst_cfg = rreads;
        @(negedge clk); do_init = 0;
        cpu_port = 3'(cpu); fwd_ports = fwd; start = 1;
        @(negedge clk); start = 0;
        if (mid) begin
            repeat (30) @(negedge clk);
            cpu_port = 3'((cpu + 1) % NP); fwd_ports = 7'h00; start = 1;   // R12: ignored while busy
            @(negedge clk); start = 0;
            cpu_port = 3'(cpu); fwd_ports = fwd;
        end
        waitc = 0;
        while (!(done || timed_out) && waitc < 5000) begin
            @(negedge clk); waitc++;
        end
        chk(waitc < 5000, "R12 run completes", waitc, 0);
        exp_to = (rreads >= POLL_MAX);
        chk(timed_out == exp_to, "R5 timed_out", timed_out, exp_to);
        chk(done == !exp_to, "R12 done", done, !exp_to);
        chk(busy == 0, "R12 busy low at end", busy, 0);
        // R2: ordered port disables
        for (int i = 0; i < NP; i++) begin
            chk(wd[i] == 5'(16 + i) && wrg[i] == 5'h04, "R2 disable address",
                {wd[i], wrg[i]}, {5'(16 + i), 5'h04});
            e = seedv(16 + i, 4) & 16'hFFFC;
            chk(wdat[i] == e, "R2 disable data", wdat[i], e);
        end
        // R3: drain gap
        chk(wcyc[7] - wcyc[6] >= DRAIN_C, "R3 drain gap", wcyc[7] - wcyc[6], DRAIN_C);
        // R4: reset write and polls
        e = seedv(27, 4) | 16'h8000;
        chk(wd[7] == 5'h1B && wrg[7] == 5'h04 && wdat[7] == e, "R4 reset write", wdat[7], e);
        pcount = exp_to ? POLL_MAX : rreads + 1;
        chk(prd_n == pcount, exp_to ? "R5 poll count" : "R4 poll count", prd_n, pcount);
        for (int i = 1; i < prd_n && i < 64; i++)
            chk(prd_cyc[i] - prd_cyc[i-1] >= POLL_C, "R4 poll gap",
                prd_cyc[i] - prd_cyc[i-1], POLL_C);
        if (exp_to) begin
            chk(wr_n == 8, "R5 no writes after timeout", wr_n, 8);
        end else begin
            n = 0;
            for (int p = 0; p < NP; p++) if (fwd[p] && p != cpu) n++;
            chk(wr_n == 12 + 3 * n, "R10 write count", wr_n, 12 + 3 * n);
            s = seedv(27, 26);
            e = (s & 16'hFF0F) | 16'(cpu << 4);
            chk(mem[27][26] == e, "R6 cpu destination", mem[27][26], e);
            for (int p = 0; p < NP; p++) begin
                d = 16 + p;
                en = (p == cpu || fwd[p]) ? 1 : 0;
                s = seedv(d, 4);
                e = (s & 16'hFFFC) | (en ? 16'h3 : 16'h0);
                chk(mem[d][4] == e, "R9 port state", mem[d][4], e);
                s = seedv(d, 7);
                e = en ? ((s & 16'hF000) | 16'(p + 1)) : s;
                chk(mem[d][7] == e, "R7 default vid", mem[d][7], e);
                s = seedv(d, 6);
                if (!en)           e = s;
                else if (p == cpu) e = (s & 16'hF800) | 16'(7'h7F & ~(7'h01 << cpu));
                else               e = (s & 16'hF800) | 16'(1 << cpu);
                chk(mem[d][6] == e, p == cpu ? "R10 cpu map" : "R8 member map", mem[d][6], e);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !timed_out && !bus_req, "R1 reset state",
            {busy, done, timed_out, bus_req}, 0);
        for (int c = 0; c < NP; c++) begin
            for (int m = 0; m < 3; m++) begin
                logic [6:0] f;
                f = (m == 0) ? 7'h7F : (m == 1) ? 7'h00 : 7'((c * 45 + 19) & 127);
                run(c, f, (c + m) % 3, (c == 3 && m == 0));
            end
        end
        run(2, 7'h55, POLL_MAX - 1, 0);   // R4: clears on the last allowed try
        run(2, 7'h55, POLL_MAX, 0);       // R5: boundary timeout
        run(5, 7'h2A, 20, 0);             // R5: stuck reset
        run(6, 7'h40, 0, 0);              // R10: only the cpu bit set; restart after timeout
        @(negedge clk);
        chk(!bus_req, "R1 idle quiet", bus_req, 0);
        summary();
    end
endmodule